// File: doc/BRIEF.md
# Two-level interrupt exception sequencer

This block decides when a simple in-order core leaves its program flow for one of two interrupt levels: a fast request and a normal request. The pipeline pulses `boundary_i` each time an instruction has completed and presents the address of the next sequential instruction on `next_pc_i`. At that point the sequencer compares the two level-sensitive request lines with the mask bits of its current status. If a request is accepted, it banks the status and the return address for the new mode, switches mode, raises the masks and issues a one-cycle `take_o` pulse with the handler address on `vec_o`.

The pipeline pulses `eret_i` when a handler executes its return instruction. The sequencer copies the banked status of the current mode back into the live status and hands the banked link value to the pipeline through `ret_valid_o`/`ret_pc_o`. The boundary that follows a return is an ordinary check point. A normal request that waited through a fast handler is therefore taken straight from the restored mode, and no instruction of the interrupted code runs in between. When a return and a boundary arrive in the same cycle, the return is applied first and the check then uses the restored status.

Top module: `irq_sequencer`

## Requirements
- R1: After reset the mode is user (5'b10000), both masks (`fmask_o`, `imask_o`) are clear, and `take_o` and `ret_valid_o` are low.
- R2: Requests are evaluated only in a cycle with `boundary_i` high. A request held without a boundary never produces `take_o`, and a boundary with no request produces nothing.
- R3: An accepted fast request gives, one clock later, a `take_o` pulse lasting exactly one cycle, `vec_o` = 32'h0000_001C, mode 5'b10001 and both masks set.
- R4: An accepted normal request gives, one clock later, a `take_o` pulse with `vec_o` = 32'h0000_0018, mode 5'b10010 and `imask_o` set, while `fmask_o` keeps the value of the status it was taken from.
- R5: When both requests are pending and unmasked at a boundary, the fast request is taken.
- R6: A fast request is ignored while `fmask_o` is set, and a normal request is ignored while `imask_o` is set. No `take_o` is produced and the mode does not change.
- R7: The link value saved on entry is the `next_pc_i` presented with the accepted boundary, and the matching return reports it on `ret_pc_o`.
- R8: `eret_i` in the fast or normal mode restores the mode and masks that were current at entry, and pulses `ret_valid_o` for one cycle with `ret_pc_o` equal to the banked link value.
- R9: When `eret_i` and `boundary_i` arrive together, the return is applied first. If a request is then accepted, its link value is the return target, not `next_pc_i`, and `ret_valid_o` stays low.
- R10: A normal request that stays pending while the fast handler runs is taken at the first boundary after the fast return, from the restored mode.
- R11: `eret_i` in user mode has no effect. There is no `ret_valid_o` pulse, and the mode and masks are unchanged.
- R12: A fast request can pre-empt a normal handler. Its return restores the normal mode with `imask_o` set, and the later normal return restores user mode and the first link value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fiq_req_i | input | 1 | Fast interrupt request, level |
| irq_req_i | input | 1 | Normal interrupt request, level |
| boundary_i | input | 1 | An instruction has completed; interrupt check point |
| next_pc_i | input | ADDR_W | Address of the next sequential instruction |
| eret_i | input | 1 | Exception-return command |
| take_o | output | 1 | One-cycle pulse: exception entry |
| vec_o | output | ADDR_W | Handler address accompanying `take_o` |
| ret_valid_o | output | 1 | One-cycle pulse: redirect to `ret_pc_o` |
| ret_pc_o | output | ADDR_W | Restored program counter |
| mode_o | output | 5 | Current mode |
| fmask_o | output | 1 | Fast request mask |
| imask_o | output | 1 | Normal request mask |

## Verification
A corrupted banked status stays hidden until the matching return. It then shows up, one clock after `eret_i`, as a wrong mode or mask value, or as a request that is taken or refused wrongly at the next boundary. A wrong link value shows only on `ret_pc_o` at that return, or, in the back-to-back case, as the return address of the chained normal handler. The reference model therefore runs nested and chained entries down to their final returns, so that every banked value is read back through the ports.

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] FIQ_VEC = 'h1C,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fiq_req_i,
  input  logic              irq_req_i,
  input  logic              boundary_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic              eret_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic              ret_valid_o,
  output logic [ADDR_W-1:0] ret_pc_o,
  output logic [4:0]        mode_o,
  output logic              fmask_o,
  output logic              imask_o
);
  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;

  // status word: {F, I, mode}
  logic [6:0]        sr_q, spsr_fiq, spsr_irq;
  logic [ADDR_W-1:0] lr_fiq, lr_irq;

  logic              in_fiq, in_irq, ret_ok, go_fiq, go_irq;
  logic [6:0]        eff_sr;
  logic [ADDR_W-1:0] bank_lr, link_val;

  assign in_fiq   = sr_q[4:0] == MODE_FIQ;
  assign in_irq   = sr_q[4:0] == MODE_IRQ;
  assign ret_ok   = eret_i && (in_fiq || in_irq);
  assign bank_lr  = in_fiq ? lr_fiq : lr_irq;
  assign eff_sr   = ret_ok ? (in_fiq ? spsr_fiq : spsr_irq) : sr_q;
  assign link_val = ret_ok ? bank_lr : next_pc_i;
  assign go_fiq   = boundary_i && fiq_req_i && !eff_sr[6];
  assign go_irq   = boundary_i && irq_req_i && !eff_sr[5] && !go_fiq;

  assign mode_o  = sr_q[4:0];
  assign fmask_o = sr_q[6];
  assign imask_o = sr_q[5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q        <= {2'b00, MODE_USR};
      spsr_fiq    <= '0;
      spsr_irq    <= '0;
      lr_fiq      <= '0;
      lr_irq      <= '0;
      take_o      <= 1'b0;
      ret_valid_o <= 1'b0;
      vec_o       <= '0;
      ret_pc_o    <= '0;
    end else begin
      take_o      <= go_fiq || go_irq;
      ret_valid_o <= ret_ok && !go_fiq && !go_irq;
      if (go_fiq) begin
        spsr_fiq <= eff_sr;
        lr_fiq   <= link_val;
        sr_q     <= {2'b11, MODE_FIQ};
        vec_o    <= FIQ_VEC;
      end else if (go_irq) begin
        spsr_irq <= eff_sr;
        lr_irq   <= link_val;
        sr_q     <= {eff_sr[6], 1'b1, MODE_IRQ};
        vec_o    <= IRQ_VEC;
      end else if (ret_ok) begin
        sr_q     <= eff_sr;
        ret_pc_o <= bank_lr;
      end
    end
  end

  AST_TAKE_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(boundary_i)); // R2
  AST_FIQ_ENTRY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o == FIQ_VEC) |-> (mode_o == MODE_FIQ && fmask_o && imask_o)); // R3
  AST_IRQ_ENTRY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o == IRQ_VEC) |-> (mode_o == MODE_IRQ && imask_o)); // R4
  AST_FIQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o == IRQ_VEC && !$past(eret_i)) |-> !($past(fiq_req_i) && !$past(fmask_o))); // R5
  AST_ENTRY_OVER_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_o && ret_valid_o)); // R9
  AST_USER_ERET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(eret_i) && $past(mode_o) == MODE_USR) |-> !ret_valid_o); // R11
endmodule

// File: tb/test_irq_sequencer.sv
module test_irq_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fiq = 1'b0, irq = 1'b0, bnd = 1'b0, ert = 1'b0;
  logic [31:0] npc = '0;
  logic        take, rv, fm, im;
  logic [31:0] vec, rpc;
  logic [4:0]  mode;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_sequencer i_irq_sequencer (
    .clk(clk), .rst_n(rst_n), .fiq_req_i(fiq), .irq_req_i(irq),
    .boundary_i(bnd), .next_pc_i(npc), .eret_i(ert),
    .take_o(take), .vec_o(vec), .ret_valid_o(rv), .ret_pc_o(rpc),
    .mode_o(mode), .fmask_o(fm), .imask_o(im));

  // reference model: bank 0 = fast, bank 1 = normal
  int          m_mode, e_vec, e_rpc;
  bit          m_f, m_i, e_take, e_rv;
  int          b_mode [2];
  bit          b_f [2], b_i [2];
  int          b_lr [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 16; m_f = 0; m_i = 0; e_take = 0; e_rv = 0;
    end else begin
      int  smode, slr, k;
      bit  sf, si, back;
      back  = ert && (m_mode == 17 || m_mode == 18);
      k     = (m_mode == 17) ? 0 : 1;
      smode = back ? b_mode[k] : m_mode;
      sf    = back ? b_f[k] : m_f;
      si    = back ? b_i[k] : m_i;
      slr   = back ? b_lr[k] : int'(npc);
      e_take = 0; e_rv = 0;
      if (bnd && fiq && !sf) begin
        b_mode[0] = smode; b_f[0] = sf; b_i[0] = si; b_lr[0] = slr;
        m_mode = 17; m_f = 1; m_i = 1; e_take = 1; e_vec = 'h1C;
      end else if (bnd && irq && !si) begin
        b_mode[1] = smode; b_f[1] = sf; b_i[1] = si; b_lr[1] = slr;
        m_mode = 18; m_f = sf; m_i = 1; e_take = 1; e_vec = 'h18;
      end else begin
        if (back) begin e_rv = 1; e_rpc = b_lr[k]; end
        m_mode = smode; m_f = sf; m_i = si;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("model take", int'(take), int'(e_take));
    chk("model ret_valid", int'(rv), int'(e_rv));
    chk("model mode", int'(mode), m_mode);
    chk("model fmask", int'(fm), int'(m_f));
    chk("model imask", int'(im), int'(m_i));
    if (e_take) chk("model vec", int'(vec), e_vec);
    if (e_rv) chk("model ret_pc", int'(rpc), e_rpc);
  end

  task automatic cyc(input bit b, input bit e, input logic [31:0] pc);
    bnd = b; ert = e; npc = pc;
    @(posedge clk);
    @(negedge clk);
    bnd = 0; ert = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mode", int'(mode), 'h10);
    chk("R1 masks", int'({fm, im}), 0);
    chk("R1 pulses", int'({take, rv}), 0);

    // R2: requests held without boundary
    fiq = 1; irq = 1;
    cyc(0, 0, 32'h100);
    cyc(0, 0, 32'h104);
    chk("R2 no take without boundary", int'(take), 0);
    chk("R2 mode unchanged", int'(mode), 'h10);

    // R3 R5: both pending, fast wins
    cyc(1, 0, 32'h110);
    chk("R3 R5 take", int'(take), 1);
    chk("R5 fast vector", int'(vec), 'h1C);
    chk("R3 mode", int'(mode), 'h11);
    chk("R3 masks", int'({fm, im}), 3);
    cyc(0, 0, 32'h0);
    chk("R3 single pulse", int'(take), 0);

    // R6: both masked inside fast handler
    cyc(1, 0, 32'h20);
    chk("R6 masked no take", int'(take), 0);
    chk("R6 mode kept", int'(mode), 'h11);

    // R9 R10 R4: return with boundary, pending normal chained
    fiq = 0;
    cyc(1, 1, 32'h24);
    chk("R10 chained take", int'(take), 1);
    chk("R4 vector", int'(vec), 'h18);
    chk("R4 mode", int'(mode), 'h12);
    chk("R4 masks", int'({fm, im}), 1);
    chk("R9 no ret_valid", int'(rv), 0);
    irq = 0;
    cyc(0, 1, 32'h0);
    chk("R9 ret target kept", int'(rpc), 'h110);
    chk("R8 ret_valid", int'(rv), 1);
    chk("R8 user restored", int'(mode), 'h10);
    chk("R8 masks restored", int'({fm, im}), 0);
    cyc(0, 0, 32'h0);
    chk("R8 ret pulse ends", int'(rv), 0);

    // R11: return in user mode
    cyc(0, 1, 32'h0);
    chk("R11 no ret_valid", int'(rv), 0);
    chk("R11 mode", int'(mode), 'h10);
    chk("R11 masks", int'({fm, im}), 0);
    cyc(1, 0, 32'h120);
    chk("R2 boundary no request", int'(take), 0);

    // R12 R7: fast pre-empts normal handler
    irq = 1;
    cyc(1, 0, 32'h300);
    chk("R4 normal alone", int'(vec), 'h18);
    fiq = 1;
    cyc(1, 0, 32'h400);
    chk("R12 preempt take", int'(take), 1);
    chk("R12 preempt vector", int'(vec), 'h1C);
    fiq = 0;
    cyc(0, 1, 32'h0);
    chk("R7 link value", int'(rpc), 'h400);
    chk("R12 back to normal", int'(mode), 'h12);
    chk("R12 masks", int'({fm, im}), 1);
    cyc(1, 0, 32'h404);
    chk("R6 normal masked", int'(take), 0);
    irq = 0;
    cyc(0, 1, 32'h0);
    chk("R12 final return pc", int'(rpc), 'h300);
    chk("R12 user mode", int'(mode), 'h10);

    // R6: fast request masked inside fast handler
    fiq = 1;
    cyc(1, 0, 32'h500);
    fiq = 1;
    cyc(1, 0, 32'h600);
    chk("R6 fast masked", int'(take), 0);
    fiq = 0;
    cyc(0, 1, 32'h0);
    chk("R7 return pc", int'(rpc), 'h500);
    repeat (3) cyc(0, 0, 32'h0);
    finish_run();
  end
endmodule